// File: doc/BRIEF.md
# Multiplexed Colour-Difference Input Formatter

This block takes an 8-bit bus on which U and V colour-difference samples arrive in alternating clock slots, one sample per luma clock. It separates the stream into a U path and a V path, removes a separate programmable signed DC offset from each to cancel clamping error made upstream, and saturates each corrected value to the unsigned 8-bit range.

Both paths then pass through a delay line of programmable depth, so that the chroma lines up with the luma pipeline. The formatter at the end produces either 4:2:2 output, with one U/V pair for every two clocks, or 4:1:1 output, in which adjacent pairs are averaged so that one pair appears every four clocks.

A line-start pulse re-aligns the slot phase. A mode input for full-screen RGB operation is passed on as a registered flag that tells the downstream chroma trap filter to step aside.

Top module: `cdiff_formatter`

## Requirements
- R1: While reset is asserted (rstN low), outValid, uOut, vOut and trapBypass are all 0.
- R2: Slots are counted 0,1,2,3,0,... from the first clock after reset. A clock with lineStart high is forced to slot 0. Even slots carry U and odd slots carry V, so a line start that lands on an odd slot turns that slot into a U slot.
- R3: Each sample is corrected as dataIn minus the offset of its component, where offsetU applies on U slots, offsetV applies on V slots, and each offset is read as a signed two's-complement 8-bit value.
- R4: A corrected value below 0 becomes 0, and a corrected value above 255 becomes 255.
- R5: For the V sample captured at rising edge k, the matching output pulse (when one is produced) is visible with outValid high after rising edge k+delaySel+1, for delaySel from 0 to 7.
- R6: With fmt411=0, every V slot produces one pulse. vOut is that V sample corrected, and uOut is the most recent U sample corrected.
- R7: With fmt411=1, only the V of slot 3 produces a pulse. The outputs are (a+b+1)>>1 per component, where a is the pair held from slot 1 (with its preceding U) and b is the current pair.
- R8: uOut and vOut hold their values on every cycle in which outValid is low.
- R9: trapBypass equals the value that rgbFullScreen had at the previous rising edge.
- R10: While delaySel is held constant, outValid is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Luma sample clock |
| rstN | input | 1 | Synchronous active-low reset |
| lineStart | input | 1 | Line-start pulse; forces the current slot to U slot 0 |
| dataIn | input | 8 | Interleaved U/V samples, unsigned |
| fmt411 | input | 1 | 1 selects 4:1:1 output, 0 selects 4:2:2 output |
| rgbFullScreen | input | 1 | Full-screen RGB mode select |
| offsetU | input | 8 | Signed offset subtracted from U samples |
| offsetV | input | 8 | Signed offset subtracted from V samples |
| delaySel | input | 3 | Alignment delay in clocks, 0 to 7 |
| uOut | output | 8 | Formatted U sample |
| vOut | output | 8 | Formatted V sample |
| outValid | output | 1 | One-clock pulse marking a new U/V pair |
| trapBypass | output | 1 | Registered request to bypass the chroma trap |

## Verification
A V sample captured at edge k produces its pulse after edge k+delaySel+1: one correction register, delaySel delay stages and one output register. The trap-bypass flag follows its input one edge later. The bench numbers its rising edges from reset release, and for each V slot it writes the expected pair into a table at index k+delaySel+1. It then samples at the falling edge after every rising edge and compares outValid, both outputs and the trap flag against that edge's table entry. Cycles with no entry are checked for a low outValid and for unchanged outputs.

// File: rtl/cdiff_pkg.sv
package cdiff_pkg;

  // Per-slot strobes from the control to the datapath.
  typedef struct packed {
    logic takeU;       // current slot carries U
    logic takeV;       // current slot carries V; closes a pair
    logic secondPair;  // pair belongs to slots 2/3 of the group
  } slotStrb_t;

endpackage

// File: rtl/cdiff_ctrl.sv
module cdiff_ctrl
  import cdiff_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineStart,
  input  logic      rgbFullScreen,
  output slotStrb_t strb,
  output logic      trapBypass
);

  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] slotNow;

  // A line start forces slot 0 (U) in the same clock.
  always_comb begin
    slotNow         = lineStart ? '0 : slotCnt;
    strb.takeU      = ~slotNow[0];
    strb.takeV      = slotNow[0];
    strb.secondPair = slotNow[SLOT_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt    <= '0;
      trapBypass <= 1'b0;
    end else begin
      slotCnt    <= slotNow + 1'b1;
      trapBypass <= rgbFullScreen;
    end
  end

endmodule

// File: rtl/cdiff_datapath.sv
module cdiff_datapath
  import cdiff_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DELAY = 7,
  localparam int DEL_W    = $clog2(MAX_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  slotStrb_t         strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] offsetU,
  input  logic [DATA_W-1:0] offsetV,
  input  logic [DEL_W-1:0]  delaySel,
  input  logic              fmt411,
  output logic [DATA_W-1:0] uOut,
  output logic [DATA_W-1:0] vOut,
  output logic              outValid
);

  localparam int WIDE_W = DATA_W + 2;
  localparam logic signed [WIDE_W-1:0] MAX_CODE = WIDE_W'((1 << DATA_W) - 1);

  // Unsigned sample minus signed offset, clamped to [0, 2^DATA_W-1].
  function automatic logic [DATA_W-1:0] subSat(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] off);
    logic signed [WIDE_W-1:0] diff;
    diff = $signed({2'b00, x}) - $signed({{2{off[DATA_W-1]}}, off});
    if (diff < 0)             subSat = '0;
    else if (diff > MAX_CODE) subSat = '1;
    else                      subSat = diff[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] avgUp(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {1'b0, a} + {1'b0, b} + 1'b1;
    avgUp = s[DATA_W:1];
  endfunction

  // Delay taps; tap 0 is the correction register.
  logic [DATA_W-1:0] tapU   [MAX_DELAY+1];
  logic [DATA_W-1:0] tapV   [MAX_DELAY+1];
  logic              tapStb [MAX_DELAY+1];
  logic              tapSec [MAX_DELAY+1];

  logic [DATA_W-1:0] corrNow;
  assign corrNow = subSat(dataIn, strb.takeV ? offsetV : offsetU);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tapU[0]   <= '0;
      tapV[0]   <= '0;
      tapStb[0] <= 1'b0;
      tapSec[0] <= 1'b0;
    end else begin
      if (strb.takeU) tapU[0] <= corrNow;
      if (strb.takeV) tapV[0] <= corrNow;
      tapStb[0] <= strb.takeV;
      tapSec[0] <= strb.secondPair;
    end
  end

  for (genvar k = 1; k <= MAX_DELAY; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tapU[k]   <= '0;
        tapV[k]   <= '0;
        tapStb[k] <= 1'b0;
        tapSec[k] <= 1'b0;
      end else begin
        tapU[k]   <= tapU[k-1];
        tapV[k]   <= tapV[k-1];
        tapStb[k] <= tapStb[k-1];
        tapSec[k] <= tapSec[k-1];
      end
    end
  end

  logic [DATA_W-1:0] selU, selV;
  logic              selStb, selSec;
  always_comb begin
    selU   = tapU[delaySel];
    selV   = tapV[delaySel];
    selStb = tapStb[delaySel];
    selSec = tapSec[delaySel];
  end

  // Output formatter.
  logic [DATA_W-1:0] firstU, firstV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstU   <= '0;
      firstV   <= '0;
      uOut     <= '0;
      vOut     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= 1'b0;
      if (selStb) begin
        if (!fmt411) begin
          uOut     <= selU;
          vOut     <= selV;
          outValid <= 1'b1;
        end else if (!selSec) begin
          firstU <= selU;
          firstV <= selV;
        end else begin
          uOut     <= avgUp(firstU, selU);
          vOut     <= avgUp(firstV, selV);
          outValid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cdiff_formatter.sv
module cdiff_formatter
  import cdiff_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DELAY = 7,
  localparam int DEL_W    = $clog2(MAX_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              fmt411,
  input  logic              rgbFullScreen,
  input  logic [DATA_W-1:0] offsetU,
  input  logic [DATA_W-1:0] offsetV,
  input  logic [DEL_W-1:0]  delaySel,
  output logic [DATA_W-1:0] uOut,
  output logic [DATA_W-1:0] vOut,
  output logic              outValid,
  output logic              trapBypass
);

  slotStrb_t strb;

  cdiff_ctrl #(.SLOT_W(2)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .lineStart    (lineStart),
    .rgbFullScreen(rgbFullScreen),
    .strb         (strb),
    .trapBypass   (trapBypass)
  );

  cdiff_datapath #(.DATA_W(DATA_W), .MAX_DELAY(MAX_DELAY)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataIn  (dataIn),
    .offsetU (offsetU),
    .offsetV (offsetV),
    .delaySel(delaySel),
    .fmt411  (fmt411),
    .uOut    (uOut),
    .vOut    (vOut),
    .outValid(outValid)
  );

endmodule

// File: rtl/cdiff_formatter_chk.sv
module cdiff_formatter_chk #(
  parameter int DATA_W = 8,
  parameter int DEL_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              rgbFullScreen,
  input logic [DEL_W-1:0]  delaySel,
  input logic [DATA_W-1:0] uOut,
  input logic [DATA_W-1:0] vOut,
  input logic              outValid,
  input logic              trapBypass
);

  AST_BYPASS_SET: assert property (@(posedge clk) disable iff (!rstN)
    rgbFullScreen |=> trapBypass); // R9

  AST_BYPASS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !rgbFullScreen |=> !trapBypass); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(uOut) && $stable(vOut))); // R8

  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> (!outValid || ($past(delaySel, 1) != $past(delaySel, 2)))); // R10

endmodule

bind cdiff_formatter cdiff_formatter_chk #(.DATA_W(DATA_W), .DEL_W(DEL_W)) u_chk (.*);

// File: tb/cdiff_formatter_tb.sv
`timescale 1ns/1ps
module cdiff_formatter_tb;

  localparam int LEN  = 160;
  localparam int TBL  = LEN + 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0;
  logic [7:0] dataIn = '0;
  logic       fmt411 = 1'b0;
  logic       rgbFullScreen = 1'b0;
  logic [7:0] offsetU = '0;
  logic [7:0] offsetV = '0;
  logic [2:0] delaySel = '0;
  logic [7:0] uOut, vOut;
  logic       outValid, trapBypass;

  int nChk = 0;
  int nErr = 0;

  bit expValid [TBL];
  int expU [TBL];
  int expV [TBL];
  bit expTrap [TBL];

  always #2.5 clk = ~clk;

  cdiff_formatter u_dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .dataIn(dataIn),
    .fmt411(fmt411), .rgbFullScreen(rgbFullScreen), .offsetU(offsetU),
    .offsetV(offsetV), .delaySel(delaySel), .uOut(uOut), .vOut(vOut),
    .outValid(outValid), .trapBypass(trapBypass)
  );

  function automatic int satSub(input int x, input int off);
    int r;
    r = x - off;
    if (r < 0)   r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  function automatic int avgUp(input int a, input int b);
    return (a + b + 1) / 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runSeg(input bit f411, input int d, input int offU, input int offV,
                        input bit randLs, input string tag);
    int slot, lastU, firstU, firstV, heldU, heldV, corr;
    bit prevValid, ls, rgb;
    string dTag;
    @(negedge clk);
    rstN = 1'b0;
    lineStart = 1'b0;
    dataIn = 8'hA5;
    rgbFullScreen = 1'b1;
    fmt411 = f411;
    delaySel = d[2:0];
    offsetU = offU[7:0];
    offsetV = offV[7:0];
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    chk(uOut == 8'd0, "R1 uOut", int'(uOut), 0);
    chk(vOut == 8'd0, "R1 vOut", int'(vOut), 0);
    chk(trapBypass == 1'b0, "R1 trapBypass", int'(trapBypass), 0);
    for (int i = 0; i < TBL; i++) begin
      expValid[i] = 1'b0; expU[i] = 0; expV[i] = 0; expTrap[i] = 1'b0;
    end
    rstN = 1'b1;
    slot = 0; lastU = 0; firstU = 0; firstV = 0; heldU = 0; heldV = 0;
    prevValid = 1'b0;
    dTag = f411 ? {"R7/", tag} : {"R6/", tag};
    for (int j = 0; j < LEN; j++) begin
      if (randLs) ls = (j == 0) || ($urandom % 7 == 0);
      else        ls = (j % 16 == 0);
      rgb = 1'($urandom % 2);
      lineStart = ls;
      dataIn = 8'($urandom % 256);
      rgbFullScreen = rgb;
      expTrap[j] = rgb;
      // Reference model from R2..R7
      if (ls) slot = 0;
      if (slot % 2 == 0) begin
        lastU = satSub(int'(dataIn), offU);
      end else begin
        corr = satSub(int'(dataIn), offV);
        if (!f411) begin
          expValid[j+d+1] = 1'b1; expU[j+d+1] = lastU; expV[j+d+1] = corr;
        end else if (slot == 1) begin
          firstU = lastU; firstV = corr;
        end else begin
          expValid[j+d+1] = 1'b1;
          expU[j+d+1] = avgUp(firstU, lastU);
          expV[j+d+1] = avgUp(firstV, corr);
        end
      end
      slot = (slot + 1) % 4;
      @(posedge clk);
      @(negedge clk);
      chk(trapBypass == expTrap[j], "R9 trapBypass", int'(trapBypass), int'(expTrap[j]));
      chk(outValid == expValid[j], {"R5 outValid/", tag}, int'(outValid), int'(expValid[j]));
      if (expValid[j]) begin
        heldU = expU[j]; heldV = expV[j];
        chk(int'(uOut) == expU[j], {dTag, " uOut"}, int'(uOut), expU[j]);
        chk(int'(vOut) == expV[j], {dTag, " vOut"}, int'(vOut), expV[j]);
      end else begin
        chk(int'(uOut) == heldU, "R8 uOut hold", int'(uOut), heldU);
        chk(int'(vOut) == heldV, "R8 vOut hold", int'(vOut), heldV);
      end
      chk(!(prevValid && outValid), "R10 consecutive pulses", int'(outValid), 0);
      prevValid = outValid;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    runSeg(1'b0, 0,    5,   -3, 1'b0, "R3");
    runSeg(1'b0, 7,   17,   40, 1'b0, "R5");
    runSeg(1'b1, 3,   -9,   22, 1'b0, "R7");
    runSeg(1'b0, 2,  127, -128, 1'b0, "R4");
    runSeg(1'b1, 7, -128,  127, 1'b0, "R4");
    runSeg(1'b0, 1,    0,    0, 1'b1, "R2");
    runSeg(1'b1, 0,   64,  -64, 1'b1, "R2");
    runSeg(1'b0, 4,   -1,    1, 1'b1, "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #(100000 * 5);
    nChk++;
    nErr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule